// File: doc/BRIEF.md
# Microcode Segment Loader with Eviction Advice

This block copies one microcode segment from a large backing memory into a small control store. A segment is a run of microinstruction words, and the last word of the run carries an end marker. The segment length is not supplied with the request. The engine finds it by streaming words from the backing memory until the marked word appears.

The engine keeps a table of resident segments. Each entry holds the length, the owning command number and a last-use stamp. From this table the engine derives the free word count.

Before writing anything, the engine first scans the segment to learn its length. It then checks whether the segment fits:

- If the segment is longer than the whole store, it raises an error.
- If the space or the descriptor slots are exhausted, it names the least recently used resident segment as the one to evict, together with its command number. The controller can then delete that command from its lookup table (using the delete input) and retry.
- Otherwise it copies the words to the requested destination, one per cycle, and then pulses done with the start and length.

Top module: `ucode_loader`

## Requirements
- R1: A request starts an upload only when `req_cmd` equals 2. Any other command number leaves `busy` low and causes no write.
- R2: Bit 31 of a backing word is the end marker. The segment length is the count of words from `req_src` up to and including the first marked word. During copy, word i of the segment is written to control-store address `req_dst + i`, one word per consecutive cycle.
- R3: `busy` is high from the cycle after the accepted request through the last cycle of the operation. The timing is:
  - a scan of L cycles (one per word);
  - one check cycle;
  - on success, L copy cycles.
- R4: `done` is a single-cycle pulse on the last copy write, with `done_addr` equal to the destination and `done_len` equal to L.
- R5: If no marker appears within the first 64 words (the store depth), `err` pulses in the 64th scan cycle and nothing is written. A segment of exactly 64 words is accepted.
- R6: `free_words` always equals 64 minus the sum of the lengths of the resident segments.
- R7: A segment does not fit when L exceeds `free_words` or all 8 descriptor slots are occupied. In that case the check cycle pulses `evict` with `evict_slot`/`evict_cmd` of the least recently used segment, and nothing is written.
- R8: A resident segment's stamp is refreshed when its upload completes and when `use_valid` names its command. `del_valid` frees the slot holding the named command. Ties on the stamp go to the lowest slot index. A new segment takes the lowest free slot. `use_valid` and `del_valid` act only while idle.
- R9: After reset, `busy`, `done`, `err`, `evict` and `cs_we` are low and `free_words` is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request strobe |
| req_cmd | input | 8 | Command number (2 = upload) |
| req_src | input | 8 | Backing memory start address |
| req_dst | input | 6 | Control-store destination address |
| req_tag | input | 8 | Command number owning the segment |
| use_valid | input | 1 | Segment use notification |
| use_cmd | input | 8 | Command number that was used |
| del_valid | input | 1 | Delete resident segment |
| del_cmd | input | 8 | Command number to delete |
| mem_re | output | 1 | Backing memory read enable |
| mem_addr | output | 8 | Backing memory read address |
| mem_rdata | input | 32 | Backing read data, one cycle after `mem_re` |
| cs_we | output | 1 | Control-store write enable |
| cs_addr | output | 6 | Control-store write address |
| cs_wdata | output | 32 | Control-store write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Upload complete pulse |
| done_addr | output | 6 | Start address of completed segment |
| done_len | output | 7 | Length of completed segment |
| err | output | 1 | Segment too long pulse |
| evict | output | 1 | No room, eviction advised pulse |
| evict_slot | output | 3 | Descriptor slot to evict |
| evict_cmd | output | 8 | Command number of slot to evict |
| free_words | output | 7 | Unused control-store words |

## Verification
Uploads cover several segment shapes, and each tells a distinct behaviour apart:
- A one-word segment checks the marker detected on the very first word.
- Five- and twenty-word segments check address stepping and data order.
- A segment filling the whole store checks the exact-fit boundary.
- A 64-word run with no marker checks the error path.

A forty-word request against a partly filled store checks the space-based eviction. It is run twice, with a use notification between resident segments, so the LRU choice shows. A stream of one-word uploads that fills every descriptor slot checks the slot-limited eviction while space remains. A non-upload command number checks that requests are filtered.

// File: rtl/ucode_loader.sv
module ucode_loader #(
  parameter int DW = 32,
  parameter int BAW = 8,
  parameter int CSW = 6,
  parameter int SLOTS = 8,
  parameter int CMDW = 8,
  parameter int TSW = 16,
  parameter int UPLOAD_CMD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [CMDW-1:0]          req_cmd,
  input  logic [BAW-1:0]           req_src,
  input  logic [CSW-1:0]           req_dst,
  input  logic [CMDW-1:0]          req_tag,
  input  logic                     use_valid,
  input  logic [CMDW-1:0]          use_cmd,
  input  logic                     del_valid,
  input  logic [CMDW-1:0]          del_cmd,
  output logic                     mem_re,
  output logic [BAW-1:0]           mem_addr,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     cs_we,
  output logic [CSW-1:0]           cs_addr,
  output logic [DW-1:0]            cs_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [CSW-1:0]           done_addr,
  output logic [CSW:0]             done_len,
  output logic                     err,
  output logic                     evict,
  output logic [$clog2(SLOTS)-1:0] evict_slot,
  output logic [CMDW-1:0]          evict_cmd,
  output logic [CSW:0]             free_words
);
  localparam int DEPTH = 1 << CSW;
  localparam int LW = CSW + 1;
  localparam int SW = $clog2(SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_CHECK, S_COPY} st_t;
  st_t st;

  logic [BAW-1:0]  src;
  logic [CSW-1:0]  dst, cnt;
  logic [CMDW-1:0] tag;
  logic [LW-1:0]   len;
  logic [SW-1:0]   slot;
  logic [TSW-1:0]  ctr;

  logic [SLOTS-1:0] d_valid;
  logic [LW-1:0]    d_len   [SLOTS];
  logic [CMDW-1:0]  d_cmd   [SLOTS];
  logic [TSW-1:0]   d_stamp [SLOTS];

  logic start, marker, last_scan, last_copy, room, have_free, use_hit, lru_found;
  logic [SW-1:0]    free_slot, lru;
  logic [TSW-1:0]   best_ts;
  logic [LW+SW-1:0] used;

  assign start     = (st == S_IDLE) && req_valid && (req_cmd == CMDW'(UPLOAD_CMD));
  assign marker    = mem_rdata[DW-1];
  assign last_scan = (cnt == CSW'(DEPTH - 1));
  assign last_copy = ((LW'(cnt) + LW'(1)) == len);

  always_comb begin
    used = '0;
    best_ts = '1;
    lru = '0;
    lru_found = 1'b0;
    have_free = 1'b0;
    free_slot = '0;
    use_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (d_valid[i]) begin
        used = used + (LW+SW)'(d_len[i]);
        if (!lru_found || d_stamp[i] < best_ts) begin
          lru_found = 1'b1;
          best_ts = d_stamp[i];
          lru = SW'(i);
        end
        if (d_cmd[i] == use_cmd) use_hit = 1'b1;
      end
    end
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!d_valid[i]) begin
        have_free = 1'b1;
        free_slot = SW'(i);
      end
    end
  end

  assign free_words = LW'(DEPTH) - LW'(used);
  assign room       = have_free && (len <= free_words);

  assign mem_re = start
               || ((st == S_SCAN) && !marker && !last_scan)
               || ((st == S_CHECK) && room)
               || ((st == S_COPY) && !last_copy);
  assign mem_addr = (st == S_IDLE)  ? req_src :
                    (st == S_CHECK) ? src : src + BAW'(cnt) + BAW'(1);

  assign busy       = (st != S_IDLE);
  assign cs_we      = (st == S_COPY);
  assign cs_addr    = dst + cnt;
  assign cs_wdata   = mem_rdata;
  assign done       = (st == S_COPY) && last_copy;
  assign done_addr  = dst;
  assign done_len   = len;
  assign err        = (st == S_SCAN) && !marker && last_scan;
  assign evict      = (st == S_CHECK) && !room;
  assign evict_slot = lru;
  assign evict_cmd  = d_cmd[lru];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0;
      dst <= '0;
      cnt <= '0;
      tag <= '0;
      len <= '0;
      slot <= '0;
      ctr <= '0;
      d_valid <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        d_len[i] <= '0;
        d_cmd[i] <= '0;
        d_stamp[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            src <= req_src;
            dst <= req_dst;
            tag <= req_tag;
            cnt <= '0;
            st  <= S_SCAN;
          end
          for (int i = 0; i < SLOTS; i++) begin
            if (use_valid && d_valid[i] && d_cmd[i] == use_cmd) d_stamp[i] <= ctr;
            if (del_valid && d_valid[i] && d_cmd[i] == del_cmd) d_valid[i] <= 1'b0;
          end
          if (use_valid && use_hit) ctr <= ctr + TSW'(1);
        end
        S_SCAN: begin
          if (marker) begin
            len <= LW'(cnt) + LW'(1);
            st  <= S_CHECK;
          end else if (last_scan) begin
            st <= S_IDLE;
          end else begin
            cnt <= cnt + CSW'(1);
          end
        end
        S_CHECK: begin
          cnt  <= '0;
          slot <= free_slot;
          st   <= room ? S_COPY : S_IDLE;
        end
        S_COPY: begin
          if (last_copy) begin
            d_valid[slot] <= 1'b1;
            d_len[slot]   <= len;
            d_cmd[slot]   <= tag;
            d_stamp[slot] <= ctr;
            ctr <= ctr + TSW'(1);
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + CSW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk #(
  parameter int CSW = 6,
  parameter int CMDW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [CMDW-1:0] req_cmd,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            evict,
  input logic            cs_we,
  input logic [CSW-1:0]  cs_addr,
  input logic [CSW:0]    free_words
);
  localparam int DEPTH = 1 << CSW;

  assert_filter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_cmd != CMDW'(2)) |=> !busy);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_we && !done) |=> (cs_we && cs_addr == $past(cs_addr) + CSW'(1)));

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> busy);

  assert_idle_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, evict}));

  assert_err_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cs_we && !$past(cs_we)));

  assert_free_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    free_words <= (CSW+1)'(DEPTH));

  assert_evict_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> !cs_we);
endmodule

bind ucode_loader ucode_loader_chk #(.CSW(CSW), .CMDW(CMDW)) chk_i (.*);

// File: tb/ucode_loader_tb_top.sv
module ucode_loader_tb_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, use_valid = 1'b0, del_valid = 1'b0;
  logic [7:0] req_cmd = '0, req_src = '0, req_tag = '0, use_cmd = '0, del_cmd = '0;
  logic [5:0] req_dst = '0;
  logic mem_re, cs_we, busy, done, err, evict;
  logic [7:0] mem_addr, evict_cmd;
  logic [31:0] mem_rdata, cs_wdata;
  logic [5:0] cs_addr, done_addr;
  logic [6:0] done_len, free_words;
  logic [2:0] evict_slot;

  always #4 clk = ~clk;

  ucode_loader dut_i (.*);

  logic [31:0] bmem [256];
  always_ff @(posedge clk) if (mem_re) mem_rdata <= bmem[mem_addr];

  typedef struct packed {
    logic busy, we; logic [5:0] addr; logic [31:0] data;
    logic done; logic [6:0] dlen; logic [5:0] daddr;
    logic err, ev; logic [2:0] eslot; logic [7:0] ecmd;
    logic commit; logic [2:0] cslot; logic [7:0] ctag;
  } rec_t;
  rec_t q[$];

  int total = 0, bad = 0;
  bit finished = 0;
  int mv[8], ml[8], mc[8], ms[8];
  int mctr = 0;

  function automatic int mfree();
    int s = DEPTH;
    for (int i = 0; i < 8; i++) if (mv[i] != 0) s -= ml[i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    rec_t r;
    @(posedge clk);
    #2;
    r = '0;
    if (q.size() > 0) r = q.pop_front();
    chk(busy == r.busy, "R3", "busy", busy, r.busy);
    chk(cs_we == r.we, "R2", "cs_we", cs_we, r.we);
    if (r.we) begin
      chk(cs_addr == r.addr, "R2", "cs_addr", cs_addr, r.addr);
      chk(cs_wdata == r.data, "R2", "cs_wdata", cs_wdata, r.data);
    end
    chk(done == r.done, "R4", "done", done, r.done);
    if (r.done) begin
      chk(done_len == r.dlen, "R4", "done_len", done_len, r.dlen);
      chk(done_addr == r.daddr, "R4", "done_addr", done_addr, r.daddr);
    end
    chk(err == r.err, "R5", "err", err, r.err);
    chk(evict == r.ev, "R7", "evict", evict, r.ev);
    if (r.ev) begin
      chk(evict_slot == r.eslot, "R8", "evict_slot", evict_slot, r.eslot);
      chk(evict_cmd == r.ecmd, "R8", "evict_cmd", evict_cmd, r.ecmd);
    end
    chk(free_words == 7'(mfree()), "R6", "free_words", free_words, mfree());
    if (r.commit) begin
      mv[r.cslot] = 1; ml[r.cslot] = int'(r.dlen); mc[r.cslot] = int'(r.ctag);
      ms[r.cslot] = mctr; mctr++;
    end
  endtask

  task automatic upload(input int src, input int dst, input int tag, input int cmd = 2);
    rec_t r;
    int len = 0, lru = 0, fs = -1;
    bit found = 0;
    if (cmd == 2) begin
      for (int k = 0; k < DEPTH; k++) begin
        r = '0; r.busy = 1;
        if (bmem[(src + k) % 256][31]) begin len = k + 1; found = 1; end
        else if (k == DEPTH - 1) r.err = 1;
        q.push_back(r);
        if (found) break;
      end
      if (found) begin
        for (int i = 7; i >= 0; i--) if (mv[i] == 0) fs = i;
        lru = -1;
        for (int i = 0; i < 8; i++) if (mv[i] != 0 && (lru < 0 || ms[i] < ms[lru])) lru = i;
        r = '0; r.busy = 1;
        if (fs < 0 || len > mfree()) begin
          r.ev = 1; r.eslot = 3'(lru); r.ecmd = 8'(mc[lru]);
          q.push_back(r);
        end else begin
          q.push_back(r);
          for (int j = 0; j < len; j++) begin
            r = '0; r.busy = 1; r.we = 1; r.addr = 6'(dst + j); r.data = bmem[(src + j) % 256];
            if (j == len - 1) begin
              r.done = 1; r.dlen = 7'(len); r.daddr = 6'(dst);
              r.commit = 1; r.cslot = 3'(fs); r.ctag = 8'(tag);
            end
            q.push_back(r);
          end
        end
      end
    end
    req_valid = 1; req_cmd = 8'(cmd); req_src = 8'(src); req_dst = 6'(dst); req_tag = 8'(tag);
    tick();
    req_valid = 0;
    while (q.size() > 0) tick();
    tick();
  endtask

  task automatic use_seg(input int cmd);
    int hit = 0;
    for (int i = 0; i < 8; i++) if (mv[i] != 0 && mc[i] == cmd) begin ms[i] = mctr; hit = 1; end
    if (hit != 0) mctr++;
    use_valid = 1; use_cmd = 8'(cmd);
    tick();
    use_valid = 0;
  endtask

  task automatic del_seg(input int cmd);
    for (int i = 0; i < 8; i++) if (mv[i] != 0 && mc[i] == cmd) mv[i] = 0;
    del_valid = 1; del_cmd = 8'(cmd);
    tick();
    del_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = {1'b0, 31'(i * 7 + 3)};
    bmem[4][31] = 1; bmem[16][31] = 1; bmem[51][31] = 1; bmem[103][31] = 1; bmem[191][31] = 1;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; ml[i] = 0; mc[i] = 0; ms[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();                       // R9 reset state
    upload(16, 0, 99, 5);         // R1 ignored command number
    upload(0, 0, 10);             // R2 R4 five words
    upload(16, 5, 11);            // R2 marker on first word
    upload(32, 6, 12);            // R2 twenty words
    use_seg(10);                  // R8 refresh A
    upload(64, 26, 13);           // R7 space eviction -> slot 1
    del_seg(11);
    upload(64, 26, 13);           // R7 R8 evict slot 2
    del_seg(12);
    upload(64, 6, 13);            // R8 lowest free slot
    upload(192, 0, 15);           // R5 no marker
    del_seg(10);
    del_seg(13);
    upload(128, 0, 14);           // R5 exact 64-word fit
    del_seg(14);
    for (int t = 0; t < 8; t++) upload(16, t, 20 + t);
    upload(16, 8, 28);            // R7 slots full -> slot 0
    use_seg(20);
    upload(16, 8, 28);            // R8 evict slot 1 after refresh
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule